// File: doc/BRIEF.md
# Block-Splitting DMA Request Sequencer

This block takes one DMA transfer at a time and turns it into a series of memory requests, each confined to a single cache block. A transfer is described by a start byte address, a byte count, a direction (read or write) and, for writes, the source bytes. The sequencer issues one block-bounded chunk on a valid/ready request channel. It waits for the response to that chunk before it issues the next one, so only one chunk is ever in flight.

An unaligned start address gives a first chunk that begins partway into a block. Every later chunk starts on a block boundary. Read responses return a whole block, and the sequencer copies the relevant byte lanes into a transfer buffer at the matching transfer position. Write acknowledgments only advance the transfer. When the last chunk has been answered, the block raises a one-cycle completion pulse that carries the transfer's tag and returns to idle.

A response that arrives when no chunk is waiting for one is dropped and reported on an error pulse.

Top module: `blk_split_dma`

## Requirements
- R1: After reset, `reqReady` is 1, and `busy`, `mreqValid`, `doneValid` and `rspErr` are 0.
- R2: A transfer is accepted on a clock edge where `reqValid` and `reqReady` are both 1. `reqReady` is 0 and `busy` is 1 from the accepting edge until completion. While busy, `reqValid` and the request fields are ignored.
- R3: The first chunk has address equal to the start address and `mreqOffset` equal to the start address modulo the block size. Its length is the smaller of the total length and the block size minus that offset.
- R4: Each later chunk has address equal to the start address plus the bytes completed so far, which is block-aligned. Its `mreqOffset` is 0 and its length is the smaller of the remaining bytes and the block size.
- R5: Only one chunk is outstanding. `mreqValid` goes low on the cycle after the chunk's handshake and rises again only after the response edge. The next chunk is presented on the cycle after a response that leaves bytes remaining.
- R6: While `mreqValid` is 1 and `mreqReady` is 0, `mreqValid` and every chunk field stay unchanged on the next cycle.
- R7: `mreqWrite` follows the transfer direction. For a write, byte lane `mreqOffset+i` of `mreqData` (lane k is bits 8k+7..8k) carries source byte `completed+i` for each i below the chunk length, and all other lanes are zero. For a read, `mreqData` is all zero.
- R8: On accept, the transfer buffer `xferBuf` (byte j is bits 8j+7..8j) is loaded from `reqWrData`. On each read response, buffer byte `completed+i` takes response lane `off+i` for each i below the in-flight byte count, where `off` is the chunk's offset. Bytes at or beyond the transfer length keep their loaded value.
- R9: On the edge that takes the response completing the last byte, `doneValid` goes high for exactly one cycle and `busy` returns to 0 at the same time.
- R10: Tags start at 0 after reset and increase by one, modulo 2^ID_W, for each accepted transfer. `doneId` gives the tag of the transfer that is completing.
- R11: A response while no chunk is waiting for one (idle, or the chunk's handshake is still pending) does not change the sequencer's state. It sets `rspErr` high for one cycle after that edge.
- R12: For a write, `rspData` on the acknowledgment has no effect, and `xferBuf` still holds the source bytes at completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transfer request offered |
| reqReady | output | 1 | Sequencer idle, can take a transfer |
| reqAddr | input | ADDR_W | Transfer start byte address |
| reqLen | input | LEN_W | Transfer length in bytes (1..MAX_BYTES) |
| reqWrite | input | 1 | 1 = write transfer, 0 = read transfer |
| reqWrData | input | MAX_BYTES*8 | Source bytes, byte j at bits 8j+7..8j |
| busy | output | 1 | A transfer is in progress |
| mreqValid | output | 1 | Chunk request valid |
| mreqReady | input | 1 | Downstream accepts the chunk |
| mreqAddr | output | ADDR_W | Chunk byte address |
| mreqWrite | output | 1 | Chunk direction |
| mreqOffset | output | log2(BLK_BYTES) | Starting lane within the block |
| mreqLen | output | log2(BLK_BYTES+1) | Chunk length in bytes |
| mreqData | output | BLK_BYTES*8 | Write bytes placed on their block lanes |
| rspValid | input | 1 | Response (read data or write acknowledgment) |
| rspData | input | BLK_BYTES*8 | Read block data |
| rspErr | output | 1 | Pulse: response arrived when none was expected |
| xferBuf | output | MAX_BYTES*8 | Transfer buffer |
| doneValid | output | 1 | Completion pulse |
| doneId | output | ID_W | Tag of the completing transfer |

## Verification
The hardest case to reach is a response that arrives while a chunk is presented but not yet accepted. The sequencer must ignore it, keep the pending chunk frozen and still finish the transfer correctly. The bench's downstream model holds `mreqReady` low for a few cycles on selected chunks and injects a stray response during that stall, then checks the error pulse and the unchanged chunk. Unaligned starts that cover every first-chunk shape are also exercised: a chunk wholly inside one block, one that ends exactly on a boundary, and a full-length transfer that spans five blocks. The tag wrap is reached by running more than 2^ID_W short transfers.

// File: rtl/blk_split_dma_pkg.sv
package blk_split_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seqState_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic load;     // accept a new transfer
    logic issued;   // current chunk handshake completed
    logic respond;  // response taken for the outstanding chunk
  } dpStrobe_t;

endpackage

// File: rtl/blk_split_dma_ctrl.sv
module blk_split_dma_ctrl
  import blk_split_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       mreqReady,
  input  logic       rspValid,
  input  logic       lastDone,
  output dpStrobe_t  strobe,
  output logic       reqReady,
  output logic       busy,
  output logic       mreqValid,
  output logic       doneValid,
  output logic       rspErr
);

  seqState_e state, stateNext;

  always_comb begin
    strobe.load    = (state == ST_IDLE)  && reqValid;
    strobe.issued  = (state == ST_ISSUE) && mreqReady;
    strobe.respond = (state == ST_WAIT)  && rspValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (strobe.load)    stateNext = ST_ISSUE;
      ST_ISSUE: if (strobe.issued)  stateNext = ST_WAIT;
      ST_WAIT:  if (strobe.respond) stateNext = lastDone ? ST_IDLE : ST_ISSUE;
      default:                      stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      doneValid <= 1'b0;
      rspErr    <= 1'b0;
    end else begin
      state     <= stateNext;
      doneValid <= strobe.respond && lastDone;
      rspErr    <= rspValid && (state != ST_WAIT);
    end
  end

  assign reqReady  = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign mreqValid = (state == ST_ISSUE);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R5
  single_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issued |=> !mreqValid);

endmodule

// File: rtl/blk_split_dma_dp.sv
module blk_split_dma_dp
  import blk_split_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 16,
  parameter int MAX_BYTES = 64,
  parameter int ID_W      = 8,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int CLEN_W   = $clog2(BLK_BYTES + 1),
  localparam int BLK_BITS = BLK_BYTES * 8,
  localparam int BUF_BITS = MAX_BYTES * 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [LEN_W-1:0]    reqLen,
  input  logic                reqWrite,
  input  logic [BUF_BITS-1:0] reqWrData,
  input  logic [BLK_BITS-1:0] rspData,
  output logic                lastDone,
  output logic [ADDR_W-1:0]   mreqAddr,
  output logic                mreqWrite,
  output logic [OFF_W-1:0]    mreqOffset,
  output logic [CLEN_W-1:0]   mreqLen,
  output logic [BLK_BITS-1:0] mreqData,
  output logic [BUF_BITS-1:0] bufData,
  output logic [ID_W-1:0]     curId
);

  logic [ADDR_W-1:0]   startAddr;
  logic [LEN_W-1:0]    totLen;
  logic [LEN_W-1:0]    issuedCnt;
  logic [LEN_W-1:0]    doneCnt;
  logic                isWr;
  logic [ID_W-1:0]     nextId;
  logic [BUF_BITS-1:0] bufReg;

  logic                firstChunk;
  logic [OFF_W-1:0]    curOff;
  int                  chunkBytes;
  int                  inFlight;
  logic [BUF_BITS-1:0] shiftedBuf;
  logic [BLK_BITS-1:0] wrSlice;
  logic [BLK_BITS-1:0] rdLanes;
  logic [BLK_BITS-1:0] rdMask;
  logic [BUF_BITS-1:0] mergeData;
  logic [BUF_BITS-1:0] mergeMask;

  // byte-lane mask covering the lowest n lanes of a block
  function automatic logic [BLK_BITS-1:0] laneMask(input int n);
    logic [BLK_BITS-1:0] m;
    for (int b = 0; b < BLK_BYTES; b++) begin
      m[b*8 +: 8] = (b < n) ? 8'hFF : 8'h00;
    end
    return m;
  endfunction

  // chunk geometry
  always_comb begin
    int room;
    int remain;
    firstChunk = (doneCnt == '0);
    curOff     = firstChunk ? startAddr[OFF_W-1:0] : '0;
    room       = BLK_BYTES - int'(curOff);
    remain     = int'(totLen) - int'(doneCnt);
    chunkBytes = (remain < room) ? remain : room;
    inFlight   = int'(issuedCnt) - int'(doneCnt);
  end

  // outgoing chunk fields and write lanes
  always_comb begin
    shiftedBuf = bufReg >> (int'(doneCnt) * 8);
    wrSlice    = shiftedBuf[BLK_BITS-1:0] & laneMask(chunkBytes);
    mreqAddr   = startAddr + ADDR_W'(doneCnt);
    mreqWrite  = isWr;
    mreqOffset = curOff;
    mreqLen    = CLEN_W'(chunkBytes);
    mreqData   = isWr ? (wrSlice << (int'(curOff) * 8)) : '0;
  end

  // read lanes moved into transfer position
  always_comb begin
    rdMask    = laneMask(inFlight);
    rdLanes   = (rspData >> (int'(curOff) * 8)) & rdMask;
    mergeData = BUF_BITS'(rdLanes) << (int'(doneCnt) * 8);
    mergeMask = BUF_BITS'(rdMask)  << (int'(doneCnt) * 8);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      totLen    <= '0;
      issuedCnt <= '0;
      doneCnt   <= '0;
      isWr      <= 1'b0;
      nextId    <= '0;
      curId     <= '0;
      bufReg    <= '0;
    end else if (strobe.load) begin
      startAddr <= reqAddr;
      totLen    <= reqLen;
      isWr      <= reqWrite;
      bufReg    <= reqWrData;
      curId     <= nextId;
      nextId    <= nextId + 1'b1;
      issuedCnt <= '0;
      doneCnt   <= '0;
    end else begin
      if (strobe.issued) begin
        issuedCnt <= issuedCnt + LEN_W'(chunkBytes);
      end
      if (strobe.respond) begin
        doneCnt <= issuedCnt;
        if (!isWr) begin
          bufReg <= (bufReg & ~mergeMask) | mergeData;
        end
      end
    end
  end

  assign lastDone = (issuedCnt == totLen);
  assign bufData  = bufReg;

  // R5
  cnt_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneCnt <= issuedCnt) && (issuedCnt <= totLen));

  // R4
  later_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneCnt != '0 && doneCnt == issuedCnt && doneCnt != totLen)
      |-> (mreqAddr[OFF_W-1:0] == '0));

endmodule

// File: rtl/blk_split_dma.sv
module blk_split_dma
  import blk_split_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 16,
  parameter int MAX_BYTES = 64,
  parameter int ID_W      = 8,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int CLEN_W   = $clog2(BLK_BYTES + 1),
  localparam int BLK_BITS = BLK_BYTES * 8,
  localparam int BUF_BITS = MAX_BYTES * 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [LEN_W-1:0]    reqLen,
  input  logic                reqWrite,
  input  logic [BUF_BITS-1:0] reqWrData,
  output logic                busy,
  output logic                mreqValid,
  input  logic                mreqReady,
  output logic [ADDR_W-1:0]   mreqAddr,
  output logic                mreqWrite,
  output logic [OFF_W-1:0]    mreqOffset,
  output logic [CLEN_W-1:0]   mreqLen,
  output logic [BLK_BITS-1:0] mreqData,
  input  logic                rspValid,
  input  logic [BLK_BITS-1:0] rspData,
  output logic                rspErr,
  output logic [BUF_BITS-1:0] xferBuf,
  output logic                doneValid,
  output logic [ID_W-1:0]     doneId
);

  dpStrobe_t strobe;
  logic      lastDone;

  blk_split_dma_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .mreqReady (mreqReady),
    .rspValid  (rspValid),
    .lastDone  (lastDone),
    .strobe    (strobe),
    .reqReady  (reqReady),
    .busy      (busy),
    .mreqValid (mreqValid),
    .doneValid (doneValid),
    .rspErr    (rspErr)
  );

  blk_split_dma_dp #(
    .ADDR_W    (ADDR_W),
    .BLK_BYTES (BLK_BYTES),
    .MAX_BYTES (MAX_BYTES),
    .ID_W      (ID_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .reqWrite   (reqWrite),
    .reqWrData  (reqWrData),
    .rspData    (rspData),
    .lastDone   (lastDone),
    .mreqAddr   (mreqAddr),
    .mreqWrite  (mreqWrite),
    .mreqOffset (mreqOffset),
    .mreqLen    (mreqLen),
    .mreqData   (mreqData),
    .bufData    (xferBuf),
    .curId      (doneId)
  );

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mreqValid && !mreqReady) |=> (mreqValid && $stable(mreqAddr) &&
      $stable(mreqLen) && $stable(mreqOffset) && $stable(mreqData)));

  // R3
  no_cross_chk: assert property (@(posedge clk) disable iff (!rstN)
    mreqValid |-> ((int'(mreqOffset) + int'(mreqLen) <= BLK_BYTES) &&
      (mreqLen != '0)));

  // R3
  offset_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    mreqValid |-> (mreqAddr[OFF_W-1:0] == mreqOffset));

endmodule

// File: tb/blk_split_dma_test.sv
`timescale 1ns/1ps
module blk_split_dma_test;

  localparam int ADDR_W   = 32;
  localparam int BLK      = 16;
  localparam int MAXB     = 64;
  localparam int ID_W     = 8;
  localparam int LEN_W    = $clog2(MAXB + 1);
  localparam int OFF_W    = $clog2(BLK);
  localparam int CLEN_W   = $clog2(BLK + 1);
  localparam int BLK_BITS = BLK * 8;
  localparam int BUF_BITS = MAXB * 8;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                reqValid = 1'b0;
  logic                reqReady;
  logic [ADDR_W-1:0]   reqAddr = '0;
  logic [LEN_W-1:0]    reqLen = '0;
  logic                reqWrite = 1'b0;
  logic [BUF_BITS-1:0] reqWrData = '0;
  logic                busy;
  logic                mreqValid;
  logic                mreqReady = 1'b0;
  logic [ADDR_W-1:0]   mreqAddr;
  logic                mreqWrite;
  logic [OFF_W-1:0]    mreqOffset;
  logic [CLEN_W-1:0]   mreqLen;
  logic [BLK_BITS-1:0] mreqData;
  logic                rspValid = 1'b0;
  logic [BLK_BITS-1:0] rspData = '0;
  logic                rspErr;
  logic [BUF_BITS-1:0] xferBuf;
  logic                doneValid;
  logic [ID_W-1:0]     doneId;

  always #2.5 clk = ~clk;

  blk_split_dma #(
    .ADDR_W(ADDR_W), .BLK_BYTES(BLK), .MAX_BYTES(MAXB), .ID_W(ID_W)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWrite(reqWrite),
    .reqWrData(reqWrData), .busy(busy), .mreqValid(mreqValid),
    .mreqReady(mreqReady), .mreqAddr(mreqAddr), .mreqWrite(mreqWrite),
    .mreqOffset(mreqOffset), .mreqLen(mreqLen), .mreqData(mreqData),
    .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr),
    .xferBuf(xferBuf), .doneValid(doneValid), .doneId(doneId)
  );

  typedef struct {
    logic [ADDR_W-1:0]   addr;
    int                  off;
    int                  len;
    logic                wr;
    logic [BLK_BITS-1:0] data;
    bit                  first;
  } chunk_t;

  chunk_t expQ[$];
  int     vectors = 0;
  int     errors = 0;
  int     stallBase = 0;
  bit     injectEarly = 0;
  int     chunkNum = 0;
  int     pokeReq = 0;
  int     pokeAck = 0;
  int     xferCount = 0;

  task automatic chk(input bit ok, input string tag, input string detail);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, detail);
    end
  endtask

  function automatic logic [7:0] memByte(input logic [ADDR_W-1:0] a);
    return 8'(a * 5 + 17);
  endfunction

  // downstream memory model and chunk monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!mreqValid && pokeReq != pokeAck) begin
        rspValid = 1'b1;
        rspData  = {BLK{8'h3C}};
        @(negedge clk);
        rspValid = 1'b0;
        chk(rspErr == 1'b1, "R11", $sformatf("idle response rspErr act %0b exp 1", rspErr));
        chk(!busy && !mreqValid, "R11", $sformatf("idle response state act busy=%0b valid=%0b exp 0 0", busy, mreqValid));
        @(negedge clk);
        chk(rspErr == 1'b0, "R11", $sformatf("rspErr pulse width act %0b exp 0", rspErr));
        pokeAck++;
      end else if (mreqValid) begin
        logic [ADDR_W-1:0]   sAddr;
        logic [CLEN_W-1:0]   sLen;
        logic [BLK_BITS-1:0] sData;
        chunk_t              e;
        int                  stall;
        stall = (chunkNum + stallBase) % 4;
        sAddr = mreqAddr; sLen = mreqLen; sData = mreqData;
        for (int s = 0; s < stall; s++) begin
          bit poke;
          poke = injectEarly && (s == 0);
          if (poke) begin
            rspValid = 1'b1;
            rspData  = {BLK{8'h5A}};
          end
          @(negedge clk);
          rspValid = 1'b0;
          if (poke) begin
            chk(rspErr == 1'b1, "R11", $sformatf("early response rspErr act %0b exp 1", rspErr));
            injectEarly = 0;
          end
          chk(mreqValid && mreqAddr == sAddr && mreqLen == sLen && mreqData == sData,
              "R6", $sformatf("stalled chunk changed act addr %h len %0d exp addr %h len %0d",
                              mreqAddr, mreqLen, sAddr, sLen));
        end
        mreqReady = 1'b1;
        if (expQ.size() == 0) begin
          chk(1'b0, "R5", $sformatf("unexpected chunk act addr %h exp none", mreqAddr));
        end else begin
          e = expQ.pop_front();
          chk(mreqAddr == e.addr && int'(mreqOffset) == e.off && int'(mreqLen) == e.len,
              e.first ? "R3" : "R4",
              $sformatf("chunk act addr %h off %0d len %0d exp addr %h off %0d len %0d",
                        mreqAddr, mreqOffset, mreqLen, e.addr, e.off, e.len));
          chk(mreqWrite == e.wr && mreqData == e.data, "R7",
              $sformatf("chunk data act wr %0b %h exp wr %0b %h", mreqWrite, mreqData, e.wr, e.data));
        end
        @(negedge clk);
        mreqReady = 1'b0;
        chk(mreqValid == 1'b0, "R5", $sformatf("valid after handshake act %0b exp 0", mreqValid));
        for (int g = 0; g < chunkNum % 2; g++) begin
          @(negedge clk);
          chk(mreqValid == 1'b0, "R5", $sformatf("valid while waiting act %0b exp 0", mreqValid));
        end
        rspValid = 1'b1;
        if (mreqWrite) begin
          rspData = {BLK{8'hA5}};
        end else begin
          for (int k = 0; k < BLK; k++) begin
            rspData[k*8 +: 8] = memByte((sAddr & ~ADDR_W'(BLK - 1)) + ADDR_W'(k));
          end
        end
        @(negedge clk);
        rspValid = 1'b0;
        chunkNum++;
      end
    end
  end

  task automatic runXfer(input logic [ADDR_W-1:0] start, input int len, input bit wr,
                         input int seed, input bit holdReq);
    logic [BUF_BITS-1:0] src;
    logic [BUF_BITS-1:0] expBuf;
    logic [ID_W-1:0]     expId;
    int                  done;
    int                  cnt;
    bit                  first;
    for (int j = 0; j < MAXB; j++) begin
      src[j*8 +: 8] = 8'(j * 13 + seed);
      expBuf[j*8 +: 8] = (!wr && j < len) ? memByte(start + ADDR_W'(j)) : 8'(j * 13 + seed);
    end
    done = 0;
    first = 1;
    while (done < len) begin
      chunk_t c;
      int room;
      c.off = first ? int'(start % BLK) : 0;
      room = BLK - c.off;
      c.len = (len - done < room) ? (len - done) : room;
      c.addr = start + ADDR_W'(done);
      c.wr = wr;
      c.first = first;
      c.data = '0;
      if (wr) begin
        for (int i = 0; i < c.len; i++) c.data[(c.off + i)*8 +: 8] = src[(done + i)*8 +: 8];
      end
      expQ.push_back(c);
      done += c.len;
      first = 0;
    end
    expId = ID_W'(xferCount);
    xferCount++;
    @(negedge clk);
    chk(reqReady == 1'b1 && busy == 1'b0, "R2", $sformatf("idle before accept act ready %0b busy %0b exp 1 0", reqReady, busy));
    reqAddr = start; reqLen = LEN_W'(len); reqWrite = wr; reqWrData = src; reqValid = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b0 && busy == 1'b1, "R2", $sformatf("after accept act ready %0b busy %0b exp 0 1", reqReady, busy));
    if (holdReq) begin
      reqAddr = 32'hDEAD_0000; reqLen = LEN_W'(3); reqWrite = ~wr; reqWrData = '1;
      @(negedge clk);
      chk(reqReady == 1'b0, "R2", $sformatf("busy ready act %0b exp 0", reqReady));
    end
    reqValid = 1'b0;
    cnt = 0;
    while (!doneValid && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
    chk(doneValid == 1'b1, "R9", $sformatf("completion act %0b exp 1", doneValid));
    chk(doneId == expId, "R10", $sformatf("tag act %0d exp %0d", doneId, expId));
    chk(busy == 1'b0 && reqReady == 1'b1, "R9", $sformatf("idle at completion act busy %0b exp 0", busy));
    chk(expQ.size() == 0, "R5", $sformatf("chunks left act %0d exp 0", expQ.size()));
    chk(xferBuf == expBuf, wr ? "R12" : "R8", $sformatf("buffer act %h exp %h", xferBuf, expBuf));
    @(negedge clk);
    chk(doneValid == 1'b0, "R9", $sformatf("pulse width act %0b exp 0", doneValid));
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, act hung exp finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reqReady && !busy && !mreqValid && !doneValid && !rspErr, "R1",
        $sformatf("reset act ready %0b busy %0b valid %0b done %0b err %0b exp 1 0 0 0 0",
                  reqReady, busy, mreqValid, doneValid, rspErr));
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !busy && !mreqValid, "R1", "state after reset release");
    // R11 response while idle
    pokeReq++;
    while (pokeAck != pokeReq) @(negedge clk);
    // single aligned read block
    runXfer(32'h0000_1000, 16, 1'b0, 1, 1'b0);
    // unaligned read over three blocks: 11,16,13
    runXfer(32'h0000_2005, 40, 1'b0, 2, 1'b0);
    // unaligned write: 13,16,1
    runXfer(32'h0000_1003, 30, 1'b1, 3, 1'b0);
    // write inside one block
    runXfer(32'h0000_3007, 4, 1'b1, 4, 1'b0);
    // first chunk ending exactly on boundary
    runXfer(32'h0000_400C, 4, 1'b0, 5, 1'b0);
    // full length unaligned read: 7,16,16,16,9
    runXfer(32'h0000_5009, 64, 1'b0, 6, 1'b0);
    // R2 held request while busy, R11 early response during a stall
    stallBase = 3 - (chunkNum % 4);
    injectEarly = 1;
    runXfer(32'h0000_6002, 20, 1'b1, 7, 1'b1);
    stallBase = 0;
    runXfer(32'h0000_7000, 64, 1'b1, 8, 1'b0);
    runXfer(32'h0000_700F, 33, 1'b0, 9, 1'b0);
    // R10 tag wrap over many short transfers
    while (xferCount < (1 << ID_W) + 4) begin
      runXfer(32'h0000_8000 + ADDR_W'(xferCount * 3), 1 + (xferCount % 3),
              xferCount[0], xferCount, 1'b0);
    end
    finishRun();
  end

endmodule